// File: doc/BRIEF.md
# Eight-Channel DAC Serial Write Driver

This block is a transmit-only SPI master that feeds an eight-channel, 12-bit serial DAC. When the driver is idle it holds `ready` high. The host places a 4-bit opcode, a 4-bit channel selector, a 12-bit code and an 8-bit configuration byte on the inputs and raises `enable`. On the first clock edge where both `ready` and `enable` are high, the block captures all four fields into one 32-bit word and drops `ready`. It then clocks the word out MSB first on `sclk` and `mosi`, with `ss_n` held low for the whole word.

The serial clock is divided down from the system clock. The division comes from two parameters: the system clock frequency and the wanted SPI frequency. An SPI frequency above 50 MHz is rejected at elaboration. `sclk` rests high while the DAC is deselected. The DAC samples `mosi` on each falling `sclk` edge, and the driver changes `mosi` only on rising edges. After each word, `ss_n` stays high for at least one full SPI period before `ready` returns. The driver does not inspect opcode or channel values: reserved codes and the all-channels selector are sent unchanged.

Top module: `dac8_spi_writer`

## Requirements
- R1: After reset `ready` is 1, `ss_n` is 1, `sclk` is 1 and `mosi` is 0.
- R2: When `enable` is high at a clock edge where `ready` is high, both `ready` and `ss_n` are 0 right after that edge.
- R3: Each word carries exactly 32 bits, MSB first. From first to last bit it is four zero bits, then `cmd[3:0]`, `addr[3:0]`, `value[11:0]` and `cfg[7:0]`.
- R4: While `ss_n` stays low, `mosi` changes only together with a rising `sclk` edge. The DAC samples on the falling edge.
- R5: The `sclk` half-period is H = ceil(SYS_CLK_HZ / (2*SPI_CLK_HZ)) system cycles, with a minimum of 1. The first falling edge comes H cycles after `ss_n` falls, and consecutive falling edges are 2H cycles apart.
- R6: `ready` rises only while `ss_n` is high, and no earlier than 2H cycles after `ss_n` rose.
- R7: Between two words, `ss_n` stays high for at least 2H system cycles.
- R8: Input changes made while `ready` is 0 do not alter the word in flight.
- R9: Every opcode 0000..1111, reserved values 1001..1111 included, and every channel selector 0000..1111, including 1111 for all channels, is sent unmodified.
- R10: `sclk` is 1 whenever `ss_n` is 1.
- R11: An `enable` pulse while `ready` is 0 starts no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start request, accepted when `ready` is high |
| cmd | input | 4 | DAC opcode |
| addr | input | 4 | Channel selector (0..7 single channel, 15 all channels) |
| value | input | 12 | DAC code |
| cfg | input | 8 | Configuration byte |
| ready | output | 1 | Idle and able to accept a request |
| sclk | output | 1 | SPI serial clock, rests high |
| mosi | output | 1 | Serial data, MSB first |
| ss_n | output | 1 | Active-low DAC select |

## Verification
- **Bad bit counter:** a bit counter that is off by one shows up at the first word. `ss_n` rises after a different number of falling edges than 32, and the captured word is shifted by one bit.
- **Bad divider:** a faulty divider shows up within two edges of the start of a word. The time to the first falling edge, or the spacing between later edges, stops matching H or 2H cycles.
- **Bad control state:** a wrong control state shows up at the next word boundary. It appears as an early `ready`, a shortened deselect gap, or a word that reflects inputs changed mid-flight.

// File: rtl/dac8_pkg.sv
package dac8_pkg;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int VAL_W   = 12;
  localparam int CFG_W   = 8;
  localparam int PAD_W   = 4;
  localparam int FRAME_W = PAD_W + CMD_W + ADDR_W + VAL_W + CFG_W;
  localparam longint SPI_MAX_HZ = 50_000_000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } xfer_state_e;

  function automatic int half_cycles(input longint sys_hz, input longint spi_hz);
    longint h;
    h = (sys_hz + 2 * spi_hz - 1) / (2 * spi_hz);
    return (h < 1) ? 1 : int'(h);
  endfunction
endpackage

// File: rtl/dac8_frame_pack.sv
module dac8_frame_pack
  import dac8_pkg::*;
(
  input  logic [CMD_W-1:0]   cmd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [VAL_W-1:0]   value,
  input  logic [CFG_W-1:0]   cfg,
  output logic [FRAME_W-1:0] word
);
  always_comb begin
    word = {{PAD_W{1'b0}}, cmd, addr, value, cfg};
  end
endmodule

// File: rtl/dac8_sclk_gen.sv
module dac8_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dac8_shift_ctrl.sv
module dac8_shift_ctrl
  import dac8_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [FRAME_W-1:0] word_in,
  input  logic               tick,
  output logic               run,
  output logic               ready,
  output logic               sclk,
  output logic               mosi,
  output logic               ss_n
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  xfer_state_e      st;
  logic [FRAME_W-1:0] sh;
  logic [BIT_W-1:0] bit_idx;
  logic             gap_half;

  assign run = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ready    <= 1'b1;
      ss_n     <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      sh       <= '0;
      bit_idx  <= '0;
      gap_half <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (enable) begin
            sh      <= word_in;
            mosi    <= word_in[FRAME_W-1];
            ss_n    <= 1'b0;
            ready   <= 1'b0;
            bit_idx <= '0;
            st      <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
            end else begin
              sclk <= 1'b1;
              if (bit_idx == LAST_BIT) begin
                st       <= ST_GAP;
                ss_n     <= 1'b1;
                mosi     <= 1'b0;
                gap_half <= 1'b0;
              end else begin
                sh      <= {sh[FRAME_W-2:0], 1'b0};
                mosi    <= sh[FRAME_W-2];
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) begin
              st    <= ST_IDLE;
              ready <= 1'b1;
            end else begin
              gap_half <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac8_spi_writer.sv
module dac8_spi_writer
  import dac8_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 100_000_000,
  parameter longint SPI_CLK_HZ = 25_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic [3:0]  cmd,
  input  logic [3:0]  addr,
  input  logic [11:0] value,
  input  logic [7:0]  cfg,
  output logic        ready,
  output logic        sclk,
  output logic        mosi,
  output logic        ss_n
);
  localparam int HALF = half_cycles(SYS_CLK_HZ, SPI_CLK_HZ);

  generate
    if (SPI_CLK_HZ > SPI_MAX_HZ || SPI_CLK_HZ <= 0) begin : g_bad_rate
      $error("dac8_spi_writer: SPI clock out of range (R5)");
    end
  endgenerate

  logic [FRAME_W-1:0] word;
  logic               run;
  logic               tick;

  dac8_frame_pack u_pack (
    .cmd   (cmd),
    .addr  (addr),
    .value (value),
    .cfg   (cfg),
    .word  (word)
  );

  dac8_sclk_gen #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  dac8_shift_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .word_in (word),
    .tick    (tick),
    .run     (run),
    .ready   (ready),
    .sclk    (sclk),
    .mosi    (mosi),
    .ss_n    (ss_n)
  );
endmodule

// File: rtl/dac8_spi_writer_chk.sv
module dac8_spi_writer_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic ready,
  input logic sclk,
  input logic mosi,
  input logic ss_n
);
  localparam int GAP_MIN = 2 * HALF;
  localparam int GW = $clog2(GAP_MIN + 2) + 1;
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_MIN + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_SAT;
    end else if (!ss_n) begin
      gap_q <= '0;
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && enable) |=> (!ready && !ss_n));

  assert_idle_clock_high_R10: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> sclk);

  assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && $past(!ss_n) && !$stable(mosi)) |-> $rose(sclk));

  assert_ready_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (ss_n && $past(ss_n)));

  assert_deselect_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ss_n) |-> (gap_q >= GW'(GAP_MIN)));

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (!ready && !ss_n) |=> !ready);
endmodule

bind dac8_spi_writer dac8_spi_writer_chk #(.HALF(HALF)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .ready  (ready),
  .sclk   (sclk),
  .mosi   (mosi),
  .ss_n   (ss_n)
);

// File: tb/tb_dac8_spi_writer.sv
module tb_dac8_spi_writer;
  localparam longint SYS_HZ = 100_000_000;
  localparam longint SPI_HZ = 25_000_000;
  localparam int H = int'((SYS_HZ + 2 * SPI_HZ - 1) / (2 * SPI_HZ));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [3:0] cmd = '0, addr = '0;
  logic [11:0] value = '0;
  logic [7:0] cfg = '0;
  logic ready, sclk, mosi, ss_n;

  always #2 clk = ~clk;

  dac8_spi_writer #(.SYS_CLK_HZ(SYS_HZ), .SPI_CLK_HZ(SPI_HZ)) dut (
    .clk(clk), .rst(rst), .enable(enable), .cmd(cmd), .addr(addr),
    .value(value), .cfg(cfg), .ready(ready), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Serial receiver model
  logic prev_ss = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0, prev_ready = 1'b1;
  logic [31:0] rx = '0, last_rx = '0;
  int nbits = 0, last_bits = 0, done_cnt = 0, start_cnt = 0;
  bit first_fall = 1'b0, seen_frame = 1'b0;
  longint t_ssfall = 0, t_ssrise = 0, t_fall = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (prev_ss && !ss_n) begin
        if (seen_frame) chk((cyc - t_ssrise) >= 2 * H, "R7 gap", cyc - t_ssrise, 2 * H);
        nbits = 0; rx = '0; first_fall = 1'b1; t_ssfall = cyc; start_cnt++;
      end
      if (!ss_n && prev_sclk && !sclk) begin
        rx = {rx[30:0], mosi};
        nbits++;
        if (first_fall) chk((cyc - t_ssfall) == H, "R5 first edge", cyc - t_ssfall, H);
        else chk((cyc - t_fall) == 2 * H, "R5 period", cyc - t_fall, 2 * H);
        first_fall = 1'b0;
        t_fall = cyc;
      end
      if (!ss_n && !prev_ss && (mosi != prev_mosi))
        chk(sclk && !prev_sclk, "R4 mosi change off rising edge", {prev_sclk, sclk}, 2'b01);
      if (!prev_ss && ss_n) begin
        last_rx = rx; last_bits = nbits; t_ssrise = cyc; seen_frame = 1'b1; done_cnt++;
      end
      if (ss_n) chk(sclk == 1'b1, "R10 idle sclk", sclk, 1);
      if (!prev_ready && ready)
        chk(ss_n && (cyc - t_ssrise) >= 2 * H, "R6 ready early", cyc - t_ssrise, 2 * H);
    end
    prev_ss = ss_n; prev_sclk = sclk; prev_mosi = mosi; prev_ready = ready;
  end

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [11:0] v,
                      input logic [7:0] g, input bit poke);
    int d0;
    while (!ready) @(negedge clk);
    cmd = c; addr = a; value = v; cfg = g; enable = 1'b1;
    d0 = done_cnt;
    @(negedge clk);
    enable = 1'b0;
    chk(!ready && !ss_n, "R2 accept", {ready, ss_n}, 2'b00);
    cmd = ~c; addr = ~a; value = ~v; cfg = ~g;  // R8: scramble during flight
    if (poke) begin
      repeat (20) @(negedge clk);
      enable = 1'b1;                              // R11: request while busy
      repeat (10) @(negedge clk);
      enable = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk(last_bits == 32, "R3 bit count", last_bits, 32);
    chk(last_rx == {4'b0000, c, a, v, g}, "R3 R8 R9 word", last_rx, {4'b0000, c, a, v, g});
  endtask

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready && ss_n && sclk && !mosi, "R1 reset state", {ready, ss_n, sclk, mosi}, 4'b1110);

    // R9: full sweep of opcodes (reserved included) and selectors (all-channels included)
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        send(4'(c), 4'(a), 12'((c * 273 + a * 91 + 5) & 12'hFFF), 8'((c * 16 + a) * 37 ^ 8'hA5), 1'b0);
      end
    end

    // corner values
    send(4'hF, 4'hF, 12'hFFF, 8'hFF, 1'b0);
    send(4'h0, 4'h0, 12'h000, 8'h00, 1'b0);
    send(4'h8, 4'h7, 12'h800, 8'h01, 1'b0);

    // R11: enable while busy must not start another word
    s0 = start_cnt;
    send(4'h3, 4'h2, 12'hA5A, 8'h3C, 1'b1);
    repeat (8 * H) @(negedge clk);
    chk(start_cnt == s0 + 1, "R11 extra word", start_cnt - s0, 1);
    chk(ss_n && ready, "R11 stays idle", {ss_n, ready}, 2'b11);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule